// File: doc/BRIEF.md
# Twin Cascadable 8-bit Timer

This block holds two 8-bit up-counters, timer A and timer B, and one 8-bit configuration register that both timers share. The two top bits of the register pick how the counters work together. They can run as two independent interval timers. They can be chained into one 16-bit timer. Timer A can drive a programmable pulse generator whose period comes from timer B's compare value. Or timer A can act as a PWM generator with a period of 64, 128 or 256 source ticks while timer B keeps running as an interval timer.

Each timer counts single-cycle enable pulses. These pulses come from a bus of prescaler taps, from an edge-detected external pin, or, for timer B, from timer A's events. Compare values arrive on two 8-bit inputs. The block drives one-cycle match pulses for each timer and a single waveform output. Every write to the configuration register restarts the block from a clean state.

Top module: `twin_timer`

## Requirements
- R1: After reset the configuration register is 0x00. The outputs are low, and timer A counts only external-pin edges, so prescaler taps alone produce no match pulse.
- R2: In mode code 00 (bits [7:6]) timer A advances once per count enable. On an enable where the count equals cmpValA it clears to 0, and matchA is high for exactly the following cycle, so matches repeat every cmpValA+1 enables. timerOut stays low.
- R3: Bits [1:0] select timer A's enable: 00 is the external-pin edge, 01 is tapEn[0], 10 is tapEn[1], 11 is tapEn[2].
- R4: Outside mode 01, bits [3:2] select timer B's enable: 00 is timer A's event, 01 is tapEn[0], 10 is tapEn[2], 11 is tapEn[3]. Timer A's event is its compare match, or the period wrap in PWM mode. Timer B matches against cmpValB by the rule of R2 and pulses matchB.
- R5: extPin passes through two synchronising flops. Each rising edge gives exactly one count enable.
- R6: In mode code 01 the counters form a 16-bit counter, {B,A}. B advances when A wraps from 0xFF, and bits [3:2] are ignored. When {B,A} equals {cmpValB,cmpValA} on an enable, both halves clear and matchB pulses, giving a period of 256*cmpValB+cmpValA+1 enables. matchA stays low.
- R7: In mode code 10, timer A restarts after the enable on which it equals cmpValB, so the period is cmpValB+1 enables. timerOut starts low and toggles on the cmpValA match (matchA) and again at the period end (matchB).
- R8: In mode code 11, bits [5:4] set the period: 01 gives 64 enables, 10 gives 128 and 11 gives 256. matchA pulses at each wrap.
- R9: In PWM mode, timerOut rises at the wrap. It falls after the enable on which the count equals the buffered compare value, so it stays high for cmp+1 enables, or for the whole period when cmp is at least period-1.
- R10: The PWM compare buffer loads cmpValA only at a wrap. A change to cmpValA mid-period takes effect from the next period.
- R11: In mode 11 with period code 00, timerOut is held low, timer A is stopped and matchA stays low.
- R12: A write to the configuration register clears both counters, the compare buffer, timerOut and both match outputs in the same cycle.
- R13: In PWM mode, timer B keeps running as an 8-bit interval timer as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeWrEn | input | 1 | Write strobe for the configuration register |
| modeWrData | input | 8 | Configuration value |
| cmpValA | input | 8 | Timer A compare value |
| cmpValB | input | 8 | Timer B compare value |
| tapEn | input | 4 | Prescaler enable pulses, four rates |
| extPin | input | 1 | External count input (asynchronous) |
| matchA | output | 1 | Timer A match / PWM wrap pulse |
| matchB | output | 1 | Timer B match / 16-bit match / PPG period pulse |
| timerOut | output | 1 | PPG or PWM waveform |

## Verification
A wrong count, a stale compare buffer or a misrouted enable shows at the ports as a match pulse or a timerOut edge that lands on the wrong cycle. This becomes visible no later than the end of the first period after the configuration write. Because every write flushes the counters, the expected pulse positions follow directly from the enable count since the write. The bench can therefore compare each cycle's outputs with an arithmetic formula, or with exact pulse counts over windows that are whole multiples of the tap rate. The 16-bit and PWM modes carry state across a full wrap, so those runs are at least two periods long.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT   = 2'b00,
    MODE_CASCADE = 2'b01,
    MODE_PPG     = 2'b10,
    MODE_PWM     = 2'b11
  } timerMode_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic flush;
    logic stepA;
    logic clearA;
    logic stepB;
    logic clearB;
    logic loadBuf;
    logic setOut;
    logic clrOut;
    logic toggleOut;
    logic pulseA;
    logic pulseB;
  } timerCtl_s;

endpackage

// File: rtl/twin_timer_dp.sv
module twin_timer_dp
  import twin_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  timerCtl_s    ctl,
  input  logic [W-1:0] cmpValA,
  input  logic [W-1:0] cmpValB,
  output logic [W-1:0] cntA,
  output logic         eqA,
  output logic         eqB,
  output logic         eqAB,
  output logic         eqBuf,
  output logic         fullA,
  output logic         matchA,
  output logic         matchB,
  output logic         timerOut
);

  logic [W-1:0] cntAQ, cntBQ, bufQ;
  logic         outQ, matchAQ, matchBQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntAQ   <= '0;
      cntBQ   <= '0;
      bufQ    <= '0;
      outQ    <= 1'b0;
      matchAQ <= 1'b0;
      matchBQ <= 1'b0;
    end else if (ctl.flush) begin
      cntAQ   <= '0;
      cntBQ   <= '0;
      bufQ    <= '0;
      outQ    <= 1'b0;
      matchAQ <= 1'b0;
      matchBQ <= 1'b0;
    end else begin
      if (ctl.clearA)     cntAQ <= '0;
      else if (ctl.stepA) cntAQ <= cntAQ + 1'b1;
      if (ctl.clearB)     cntBQ <= '0;
      else if (ctl.stepB) cntBQ <= cntBQ + 1'b1;
      if (ctl.loadBuf)    bufQ  <= cmpValA;
      if (ctl.setOut)         outQ <= 1'b1;
      else if (ctl.clrOut)    outQ <= 1'b0;
      else if (ctl.toggleOut) outQ <= ~outQ;
      matchAQ <= ctl.pulseA;
      matchBQ <= ctl.pulseB;
    end
  end

  assign cntA     = cntAQ;
  assign eqA      = (cntAQ == cmpValA);
  assign eqB      = (cntBQ == cmpValB);
  assign eqAB     = (cntAQ == cmpValB);
  assign eqBuf    = (cntAQ == bufQ);
  assign fullA    = &cntAQ;
  assign matchA   = matchAQ;
  assign matchB   = matchBQ;
  assign timerOut = outQ;

endmodule

// File: rtl/twin_timer_ctrl.sv
module twin_timer_ctrl
  import twin_timer_pkg::*;
#(
  parameter int W       = 8,
  parameter int SYNC_FF = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeWrEn,
  input  logic [7:0]   modeWrData,
  input  logic [3:0]   tapEn,
  input  logic         extPin,
  input  logic [W-1:0] cntA,
  input  logic         eqA,
  input  logic         eqB,
  input  logic         eqAB,
  input  logic         eqBuf,
  input  logic         fullA,
  output timerCtl_s    ctl
);

  localparam int SYNC_LEN = SYNC_FF + 1;

  logic [7:0]          cfgQ;
  logic [SYNC_LEN-1:0] syncQ;
  timerMode_e          mode;
  logic [1:0]          period, clkASel, clkBSel;
  logic                extEdge, enA, enB, aEvent, hit16, endP, midP, wrapA;
  logic [W-1:0]        lastCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      syncQ <= '0;
    end else begin
      if (modeWrEn) cfgQ <= modeWrData;
      syncQ <= {syncQ[SYNC_LEN-2:0], extPin};
    end
  end

  assign mode    = timerMode_e'(cfgQ[7:6]);
  assign period  = cfgQ[5:4];
  assign clkBSel = cfgQ[3:2];
  assign clkASel = cfgQ[1:0];
  assign extEdge = syncQ[SYNC_LEN-2] & ~syncQ[SYNC_LEN-1];

  always_comb begin
    unique case (clkASel)
      2'b00:   enA = extEdge;
      2'b01:   enA = tapEn[0];
      2'b10:   enA = tapEn[1];
      default: enA = tapEn[2];
    endcase

    lastCnt = {W{1'b1}} >> (2'd3 - period);
    wrapA   = enA & (cntA == lastCnt) & (period != 2'b00);
    aEvent  = (mode == MODE_PWM) ? wrapA : (enA & eqA);

    unique case (clkBSel)
      2'b00:   enB = aEvent;
      2'b01:   enB = tapEn[0];
      2'b10:   enB = tapEn[2];
      default: enB = tapEn[3];
    endcase

    hit16 = enA & eqA & eqB;
    endP  = enA & eqAB;
    midP  = enA & eqA & ~eqAB;

    ctl = '0;
    if (modeWrEn) begin
      ctl.flush = 1'b1;
    end else begin
      unique case (mode)
        MODE_CASCADE: begin
          ctl.clearA = hit16;
          ctl.clearB = hit16;
          ctl.pulseB = hit16;
          ctl.stepA  = enA & ~hit16;
          ctl.stepB  = enA & ~hit16 & fullA;
        end
        MODE_PPG: begin
          ctl.clearA    = endP;
          ctl.stepA     = enA & ~endP;
          ctl.toggleOut = endP | midP;
          ctl.pulseA    = midP;
          ctl.pulseB    = endP;
        end
        default: begin
          // timer B is a plain interval timer in split and PWM modes
          ctl.stepB  = enB & ~eqB;
          ctl.clearB = enB & eqB;
          ctl.pulseB = enB & eqB;
          if (mode == MODE_SPLIT) begin
            ctl.stepA  = enA & ~eqA;
            ctl.clearA = enA & eqA;
            ctl.pulseA = enA & eqA;
          end else if (period == 2'b00) begin
            ctl.clrOut = 1'b1;
          end else begin
            ctl.clearA  = wrapA;
            ctl.stepA   = enA & ~wrapA;
            ctl.setOut  = wrapA;
            ctl.loadBuf = wrapA;
            ctl.pulseA  = wrapA;
            ctl.clrOut  = enA & ~wrapA & eqBuf;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import twin_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeWrEn,
  input  logic [7:0]   modeWrData,
  input  logic [W-1:0] cmpValA,
  input  logic [W-1:0] cmpValB,
  input  logic [3:0]   tapEn,
  input  logic         extPin,
  output logic         matchA,
  output logic         matchB,
  output logic         timerOut
);

  timerCtl_s    ctl;
  logic [W-1:0] cntA;
  logic         eqA, eqB, eqAB, eqBuf, fullA;

  twin_timer_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .tapEn(tapEn), .extPin(extPin), .cntA(cntA), .eqA(eqA), .eqB(eqB),
    .eqAB(eqAB), .eqBuf(eqBuf), .fullA(fullA), .ctl(ctl)
  );

  twin_timer_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmpValA(cmpValA), .cmpValB(cmpValB),
    .cntA(cntA), .eqA(eqA), .eqB(eqB), .eqAB(eqAB), .eqBuf(eqBuf),
    .fullA(fullA), .matchA(matchA), .matchB(matchB), .timerOut(timerOut)
  );

endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       modeWrEn,
  input logic [3:0] modeHi,
  input logic       matchA,
  input logic       matchB,
  input logic       timerOut
);

  logic [1:0] shMode, shPer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shMode <= 2'b00;
      shPer  <= 2'b00;
    end else if (modeWrEn) begin
      shMode <= modeHi[3:2];
      shPer  <= modeHi[1:0];
    end
  end

  assert_out_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (shMode == 2'b00 || shMode == 2'b01) |-> !timerOut);

  assert_cascade_quiet_a_R6: assert property (@(posedge clk) disable iff (!rstN)
    (shMode == 2'b01) |-> !matchA);

  assert_ppg_toggle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (shMode == 2'b10 && (matchA || matchB)) |-> (timerOut != $past(timerOut)));

  assert_ppg_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (shMode == 2'b10 && !matchA && !matchB && !$past(modeWrEn)) |-> $stable(timerOut));

  assert_pwm_rise_at_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (shMode == 2'b11 && shPer != 2'b00 && $rose(timerOut)) |-> matchA);

  assert_reserved_silent_R11: assert property (@(posedge clk) disable iff (!rstN)
    (shMode == 2'b11 && shPer == 2'b00) |-> (!timerOut && !matchA));

  assert_flush_clears_R12: assert property (@(posedge clk) disable iff (!rstN)
    modeWrEn |=> (!timerOut && !matchA && !matchB));

endmodule

bind twin_timer twin_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeHi(modeWrData[7:4]),
  .matchA(matchA), .matchB(matchB), .timerOut(timerOut)
);

// File: tb/tb_twin_timer.sv
module tb_twin_timer;

  logic       clk = 1'b0;
  logic       rstN;
  logic       modeWrEn;
  logic [7:0] modeWrData, cmpValA, cmpValB;
  logic [3:0] tapEn;
  logic       extPin;
  logic       matchA, matchB, timerOut;

  int nChecks = 0;
  int nFails  = 0;
  int ph      = 0;
  int seenA   = 0;
  int seenB   = 0;

  always #5 clk = ~clk;

  twin_timer dut (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .cmpValA(cmpValA), .cmpValB(cmpValB), .tapEn(tapEn), .extPin(extPin),
    .matchA(matchA), .matchB(matchB), .timerOut(timerOut)
  );

  // prescaler taps: every cycle, every 4th, 16th, 256th
  initial begin
    tapEn = 4'b0000;
    forever begin
      @(negedge clk);
      ph++;
      tapEn = {(ph % 256 == 0), (ph % 16 == 0), (ph % 4 == 0), 1'b1};
    end
  end

  always @(posedge clk) begin
    #1;
    if (rstN && matchA) seenA++;
    if (rstN && matchB) seenB++;
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic writeMode(input logic [7:0] d);
    @(negedge clk);
    modeWrEn   = 1'b1;
    modeWrData = d;
    @(negedge clk);
    modeWrEn   = 1'b0;
  endtask

  task automatic pulsePin(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); extPin = 1'b1;
      @(negedge clk);
      @(negedge clk); extPin = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic splitRun(input int c);
    cmpValA = c[7:0];
    cmpValB = 8'hFF;
    writeMode(8'b00_00_00_01);
    for (int i = 1; i <= 3 * (c + 1) + 2; i++) begin
      @(negedge clk);
      checkEq($sformatf("R2 split c=%0d i=%0d matchA", c, i), int'(matchA), int'(i % (c + 1) == 0));
      checkEq("R2 split timerOut", int'(timerOut), 0);
    end
  endtask

  task automatic windowRun(input string tag, input logic [7:0] m, input int cA,
                           input int cB, input int len, input int expA, input int expB);
    int baseA, baseB;
    cmpValA = cA[7:0];
    cmpValB = cB[7:0];
    writeMode(m);
    baseA = seenA;
    baseB = seenB;
    repeat (len) @(negedge clk);
    checkEq({tag, " matchA count"}, seenA - baseA, expA);
    checkEq({tag, " matchB count"}, seenB - baseB, expB);
  endtask

  task automatic ppgRun(input int cA, input int cB);
    cmpValA = cA[7:0];
    cmpValB = cB[7:0];
    writeMode(8'b10_00_00_01);
    for (int i = 1; i <= 4 * (cB + 1); i++) begin
      int r;
      @(negedge clk);
      r = i % (cB + 1);
      checkEq($sformatf("R7 ppg i=%0d timerOut", i), int'(timerOut), int'(r >= cA + 1));
      checkEq("R7 ppg matchA", int'(matchA), int'(r == cA + 1));
      checkEq("R7 ppg matchB", int'(matchB), int'(r == 0));
    end
  endtask

  task automatic pwmRun(input int code, input int c1, input int c2);
    int p;
    p = 1 << (5 + code);
    cmpValA = c1[7:0];
    cmpValB = 8'd4;
    writeMode({2'b11, code[1:0], 2'b01, 2'b01});
    for (int i = 1; i <= 3 * p; i++) begin
      int r, c, hi;
      @(negedge clk);
      if (i < p) hi = 0;
      else begin
        r  = (i - p) % p;
        c  = (i < 2 * p) ? c1 : c2;
        hi = (c >= p - 1) || (r <= c);
      end
      checkEq($sformatf("R9/R10 pwm p=%0d i=%0d timerOut", p, i), int'(timerOut), hi);
      checkEq("R8 pwm wrap matchA", int'(matchA), int'(i % p == 0));
      checkEq("R13 pwm timer B matchB", int'(matchB), int'(i % 5 == 0));
      if (i == p + 2) cmpValA = c2[7:0];
    end
  endtask

  initial begin
    int baseA;
    rstN = 1'b0; modeWrEn = 1'b0; modeWrData = 8'h00;
    cmpValA = 8'h00; cmpValB = 8'h00; extPin = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R1 reset matchA", int'(matchA), 0);
    checkEq("R1 reset matchB", int'(matchB), 0);
    checkEq("R1 reset timerOut", int'(timerOut), 0);
    rstN = 1'b1;
    baseA = seenA;
    repeat (50) @(negedge clk);
    checkEq("R1 R3 taps ignored after reset", seenA - baseA, 0);

    // R5 R3: external pin as timer A clock
    cmpValA = 8'd2;
    writeMode(8'h00);
    baseA = seenA;
    pulsePin(2); repeat (6) @(negedge clk);
    checkEq("R5 two edges, no match", seenA - baseA, 0);
    pulsePin(1); repeat (6) @(negedge clk);
    checkEq("R5 third edge matches", seenA - baseA, 1);
    pulsePin(6); repeat (6) @(negedge clk);
    checkEq("R5 nine edges", seenA - baseA, 3);

    // R2 near-exhaustive compare sweep
    for (int c = 0; c < 16; c++) splitRun(c);
    splitRun(255);

    // R4 timer B from timer A match, exact positions
    cmpValA = 8'd2; cmpValB = 8'd1;
    writeMode(8'b00_00_00_01);
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      checkEq($sformatf("R4 chain i=%0d matchB", i), int'(matchB), int'(i % 6 == 0));
    end

    // R3 R4 tap selections
    windowRun("R3 A tap4",     8'b00_00_11_10, 2,   255, 48,  4, 0);
    windowRun("R3 A tap16",    8'b00_00_11_11, 1,   255, 96,  3, 0);
    windowRun("R4 B tap16",    8'b00_00_10_11, 255, 2,   96,  0, 2);
    windowRun("R4 B tap256",   8'b00_00_11_01, 255, 0,   512, 2, 2);
    windowRun("R4 B tap1",     8'b00_00_01_11, 1,   6,   224, 7, 32);

    // R6 cascade, B select field set to a tap that must be ignored
    cmpValA = 8'd3; cmpValB = 8'd2;
    writeMode(8'b01_00_11_01);
    for (int i = 1; i <= 1040; i++) begin
      @(negedge clk);
      checkEq($sformatf("R6 cascade i=%0d matchB", i), int'(matchB), int'(i % 516 == 0));
      checkEq("R6 cascade matchA", int'(matchA), 0);
    end

    // R7 PPG
    ppgRun(3, 9);
    ppgRun(0, 5);
    ppgRun(6, 7);

    // R8 R9 R10 R13 PWM periods, duties and buffered reload
    pwmRun(1, 10, 40);
    pwmRun(1, 0, 63);
    pwmRun(2, 100, 5);
    pwmRun(3, 200, 255);

    // R11 reserved period
    cmpValA = 8'd3;
    writeMode(8'b11_00_01_01);
    baseA = seenA;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      if (timerOut) checkEq("R11 reserved timerOut", 1, 0);
    end
    checkEq("R11 reserved timerOut end", int'(timerOut), 0);
    checkEq("R11 reserved no matchA", seenA - baseA, 0);

    // R12 mid-run write restarts timing
    cmpValA = 8'd9; cmpValB = 8'hFF;
    writeMode(8'b00_00_00_01);
    repeat (5) @(negedge clk);
    writeMode(8'b00_00_00_01);
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      checkEq($sformatf("R12 restart i=%0d matchA", i), int'(matchA), int'(i == 10));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #1500000;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule